// File: doc/BRIEF.md
# Lockable Watchdog Timer with Reset Escalation

This block is a down-counting watchdog that sits on a simple register port. The port carries an address, write data, a write strobe, a read strobe and read data. Software sets a reload value and turns the counter on. After that it must keep the timer from expiring.

When the count runs out the first time, the block raises a timeout flag. The flag drives either the normal interrupt line or the non-maskable interrupt line, and the counter starts again from the reload value. If the count runs out again while the flag is still set, and reset escalation is on, the block asks for a system reset. After that request the block holds still until the next hardware reset.

Configuration writes can be blocked by a lock register that opens only for one 32-bit key. The enable bit cannot be cleared by software. A debug-stall option freezes the count while an external debug-halt input is high.

Top module: `wdog_lockable`

## Requirements
- R1: After reset, LOAD (0x000) reads all ones. Every other register reads 0, and irq_o, nmi_o and sysrst_o are low.
- R2: Writing 0x1ACCE551 to LOCK (0xC00) unlocks configuration. Any other value written there locks it. LOCK reads 1 when locked and 0 when unlocked. The block comes out of reset unlocked.
- R3: While locked, writes to LOAD and to CTL (0x008) change nothing. Writes to ICR (0x00C), TEST (0x418) and LOCK still take effect.
- R4: CTL bit 0 (enable) is sticky. Writing 0 to it never clears it; only rst_n does.
- R5: An accepted write that sets enable loads the counter from LOAD on that edge. Each later cycle the counter goes down by one. On a cycle where it is already 0, it expires instead: RIS bit 0 is set and the counter reloads from LOAD. The period is therefore LOAD+1 cycles.
- R6: If an expiry happens while RIS bit 0 is already set and CTL bit 1 (reset enable) is set, sysrst_o goes high for exactly 4 cycles. From that edge VALUE (0x004) stays 0 until rst_n, and no further expiry occurs. With CTL bit 1 clear, a repeated expiry only reloads.
- R7: An accepted LOAD write while enabled puts the new value into the counter on that edge. A value of 0 counts as an immediate expiry.
- R8: irq_o = RIS & enable & ~CTL bit 2. nmi_o = RIS & enable & CTL bit 2. So bit 2 = 1 routes timeouts to the non-maskable line.
- R9: Writing 1 to ICR bit 0 clears RIS bit 0. If an expiry falls in the same cycle, the expiry wins. MIS (0x014) bit 0 reads RIS bit 0 AND enable.
- R10: When TEST bit 8 (stall) is set and dbg_halt is high, the counter holds its value. With stall clear, dbg_halt has no effect.
- R11: bus_rdata shows the addressed register while bus_re is high. It is 0 when bus_re is low or the address is unmapped. ICR reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from address |
| dbg_halt | input | 1 | Debugger has halted the processor |
| irq_o | output | 1 | Maskable timeout interrupt |
| nmi_o | output | 1 | Non-maskable timeout interrupt |
| sysrst_o | output | 1 | System reset request pulse |

## Verification
On every cycle the assertions check several behaviours:
- enable never drops once set;
- a locked LOAD write leaves the reload value untouched;
- an enabled, unstalled, non-zero counter steps down by exactly one;
- a stalled counter holds;
- an accepted non-zero LOAD write lands in the counter on the next cycle;
- the reset pulse lasts exactly four cycles, and after it the counter stays at zero.

Only the bench scenarios show the other behaviours: the key semantics of the lock register, the choice between the two interrupt lines, a clear that collides with an expiry, the zero-load expiry, and whether a second expiry escalates or only reloads depending on the reset-enable bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int ADDR_W = 12;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ICR   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RIS   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MIS   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_TEST  = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  localparam int CTL_EN_BIT     = 0;
  localparam int CTL_RSTEN_BIT  = 1;
  localparam int CTL_ITYPE_BIT  = 2;
  localparam int TEST_STALL_BIT = 8;
  localparam int ICR_CLR_BIT    = 0;

  typedef struct packed {
    logic itype;
    logic rsten;
    logic en;
  } ctl_t;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LOAD,
    SEL_VALUE,
    SEL_CTL,
    SEL_ICR,
    SEL_RIS,
    SEL_MIS,
    SEL_TEST,
    SEL_LOCK
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_LOAD:  s = SEL_LOAD;
      OFS_VALUE: s = SEL_VALUE;
      OFS_CTL:   s = SEL_CTL;
      OFS_ICR:   s = SEL_ICR;
      OFS_RIS:   s = SEL_RIS;
      OFS_MIS:   s = SEL_MIS;
      OFS_TEST:  s = SEL_TEST;
      OFS_LOCK:  s = SEL_LOCK;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ris,
  output logic [CNT_W-1:0]  load_q,
  output ctl_t              ctl_q,
  output logic              stall_q,
  output logic              locked_q,
  output logic              load_acc,
  output logic              en_rise,
  output logic              icr_clr,
  output logic [DATA_W-1:0] rdata
);

  reg_sel_e sel;
  logic ctl_acc, test_wr, lock_wr;
  logic [CNT_W-1:0] load_d;
  ctl_t ctl_d;
  logic stall_d, locked_d;

  assign sel = decode(addr);

  // write qualification: lock gates only the load and control registers
  always_comb begin
    load_acc = we && (sel == SEL_LOAD) && !locked_q;
    ctl_acc  = we && (sel == SEL_CTL)  && !locked_q;
    test_wr  = we && (sel == SEL_TEST);
    lock_wr  = we && (sel == SEL_LOCK);
    icr_clr  = we && (sel == SEL_ICR) && wdata[ICR_CLR_BIT];
    en_rise  = ctl_acc && wdata[CTL_EN_BIT] && !ctl_q.en;
  end

  // next state
  always_comb begin
    load_d   = load_q;
    ctl_d    = ctl_q;
    stall_d  = stall_q;
    locked_d = locked_q;
    if (load_acc) load_d = wdata[CNT_W-1:0];
    if (ctl_acc) begin
      ctl_d.en    = ctl_q.en | wdata[CTL_EN_BIT];
      ctl_d.rsten = wdata[CTL_RSTEN_BIT];
      ctl_d.itype = wdata[CTL_ITYPE_BIT];
    end
    if (test_wr) stall_d = wdata[TEST_STALL_BIT];
    if (lock_wr) locked_d = (wdata != UNLOCK_KEY);
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '1;
      ctl_q    <= '0;
      stall_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (load_acc) load_q   <= load_d;
      if (ctl_acc)  ctl_q    <= ctl_d;
      if (test_wr)  stall_q  <= stall_d;
      if (lock_wr)  locked_q <= locked_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (re) begin
      case (sel)
        SEL_LOAD:  rdata[CNT_W-1:0] = load_q;
        SEL_VALUE: rdata[CNT_W-1:0] = cnt;
        SEL_CTL: begin
          rdata[CTL_EN_BIT]    = ctl_q.en;
          rdata[CTL_RSTEN_BIT] = ctl_q.rsten;
          rdata[CTL_ITYPE_BIT] = ctl_q.itype;
        end
        SEL_RIS:   rdata[0] = ris;
        SEL_MIS:   rdata[0] = ris & ctl_q.en;
        SEL_TEST:  rdata[TEST_STALL_BIT] = stall_q;
        SEL_LOCK:  rdata[0] = locked_q;
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rsten,
  input  logic             stall,
  input  logic             dbg_halt,
  input  logic             frozen,
  input  logic             load_acc,
  input  logic             en_rise,
  input  logic             icr_clr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ris_q,
  output logic             rst_trig
);

  logic tick, hit_zero, wr_now, expire;
  logic [CNT_W-1:0] cnt_d;
  logic cnt_upd, ris_d, ris_upd;

  always_comb begin
    tick     = en && !frozen && !(stall && dbg_halt);
    hit_zero = (cnt_q == '0);
    wr_now   = load_acc && en && !frozen;
    expire   = !frozen &&
               ((wr_now && (wr_val == '0)) ||
                (!wr_now && !en_rise && tick && hit_zero));
    rst_trig = expire && ris_q && rsten;
  end

  // counter next state
  always_comb begin
    cnt_d   = cnt_q;
    cnt_upd = 1'b0;
    if (rst_trig) begin
      cnt_d   = '0;
      cnt_upd = 1'b1;
    end else if (frozen) begin
      cnt_upd = 1'b0;
    end else if (wr_now) begin
      cnt_d   = wr_val;
      cnt_upd = 1'b1;
    end else if (en_rise) begin
      cnt_d   = load_val;
      cnt_upd = 1'b1;
    end else if (tick) begin
      cnt_d   = hit_zero ? load_val : cnt_q - CNT_W'(1);
      cnt_upd = 1'b1;
    end
  end

  // timeout flag: an expiry outranks a clear in the same cycle
  always_comb begin
    ris_upd = expire || icr_clr;
    ris_d   = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ris_q <= 1'b0;
    end else begin
      if (cnt_upd) cnt_q <= cnt_d;
      if (ris_upd) ris_q <= ris_d;
    end
  end

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic sysrst,
  output logic frozen_q
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] rcnt_q, rcnt_d;
  logic rcnt_upd;

  always_comb begin
    rcnt_d   = rcnt_q;
    rcnt_upd = 1'b0;
    if (trig) begin
      rcnt_d   = CW'(RST_CYCLES);
      rcnt_upd = 1'b1;
    end else if (rcnt_q != '0) begin
      rcnt_d   = rcnt_q - CW'(1);
      rcnt_upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (rcnt_upd) rcnt_q <= rcnt_d;
      if (trig)     frozen_q <= 1'b1;
    end
  end

  assign sysrst = (rcnt_q != '0);

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              sysrst_o
);

  logic [CNT_W-1:0] load_q, cnt_q;
  ctl_t ctl_q;
  logic stall_q, locked_q, ris_q;
  logic load_acc, en_rise, icr_clr, rst_trig, frozen_q;
  logic en_s, rsten_s, itype_s;

  assign en_s    = ctl_q.en;
  assign rsten_s = ctl_q.rsten;
  assign itype_s = ctl_q.itype;

  wdog_cfg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .we       (bus_we),
    .re       (bus_re),
    .cnt      (cnt_q),
    .ris      (ris_q),
    .load_q   (load_q),
    .ctl_q    (ctl_q),
    .stall_q  (stall_q),
    .locked_q (locked_q),
    .load_acc (load_acc),
    .en_rise  (en_rise),
    .icr_clr  (icr_clr),
    .rdata    (bus_rdata)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_s),
    .rsten    (rsten_s),
    .stall    (stall_q),
    .dbg_halt (dbg_halt),
    .frozen   (frozen_q),
    .load_acc (load_acc),
    .en_rise  (en_rise),
    .icr_clr  (icr_clr),
    .load_val (load_q),
    .wr_val   (bus_wdata[CNT_W-1:0]),
    .cnt_q    (cnt_q),
    .ris_q    (ris_q),
    .rst_trig (rst_trig)
  );

  wdog_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (rst_trig),
    .sysrst   (sysrst_o),
    .frozen_q (frozen_q)
  );

  // interrupt routing by type bit
  assign irq_o = ris_q & en_s & ~itype_s;
  assign nmi_o = ris_q & en_s &  itype_s;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sysrst_o,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load,
  input logic              locked,
  input logic              stall,
  input logic              dbg_halt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata
);

  localparam int HW = $clog2(RST_CYCLES + 2);

  logic [HW-1:0] hi_cnt;
  logic seen_rst, frozen_p, cfg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      seen_rst <= 1'b0;
    end else begin
      hi_cnt <= sysrst_o ? hi_cnt + HW'(1) : '0;
      if (sysrst_o) seen_rst <= 1'b1;
    end
  end

  assign frozen_p = sysrst_o || seen_rst;
  assign cfg_wr   = bus_we && ((bus_addr == OFS_LOAD) || (bus_addr == OFS_CTL));

  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  // R3
  locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_we && (bus_addr == OFS_LOAD)) |=> $stable(load));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frozen_p && (cnt != '0) && !(stall && dbg_halt) && !cfg_wr)
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && dbg_halt && !cfg_wr) |=> $stable(cnt));

  // R7
  load_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !locked && !frozen_p && bus_we && (bus_addr == OFS_LOAD) && (bus_wdata != '0))
      |=> (cnt == $past(bus_wdata)));

  // R6
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_o |-> (hi_cnt < HW'(RST_CYCLES)));

  // R6
  rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysrst_o) |-> (hi_cnt == HW'(RST_CYCLES)));

  // R6
  frozen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_rst |-> (cnt == '0));

endmodule

bind wdog_lockable wdog_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sysrst_o  (sysrst_o),
  .en        (en_s),
  .cnt       (cnt_q),
  .load      (load_q),
  .locked    (locked_q),
  .stall     (stall_q),
  .dbg_halt  (dbg_halt),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata[CNT_W-1:0])
);

// File: tb/test_wdog_lockable.sv
module test_wdog_lockable;

  localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTL = 12'h008,
                          A_ICR = 12'h00C, A_RIS = 12'h010, A_MIS = 12'h014,
                          A_TEST = 12'h418, A_LOCK = 12'hC00, A_BAD = 12'h020;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] b_addr;
  logic [31:0] b_wdata;
  logic b_we, b_re, b_halt;
  logic [31:0] b_rdata;
  logic irq_o, nmi_o, sysrst_o;

  int vec = 0;
  int bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  wdog_lockable i_wdog_lockable (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_we(b_we), .bus_re(b_re), .bus_rdata(b_rdata), .dbg_halt(b_halt),
    .irq_o(irq_o), .nmi_o(nmi_o), .sysrst_o(sysrst_o)
  );

  // behavioural reference state
  logic [31:0] m_load, m_cnt;
  logic m_en, m_rsten, m_itype, m_stall, m_lock, m_ris, m_frozen;
  int m_rst_left;

  always @(posedge clk or negedge rst_n) begin
    logic ld, ct, ex, tr;
    if (!rst_n) begin
      m_load = '1; m_cnt = 0; m_en = 0; m_rsten = 0; m_itype = 0;
      m_stall = 0; m_lock = 0; m_ris = 0; m_frozen = 0; m_rst_left = 0;
    end else begin
      ld = b_we && b_addr == A_LOAD && !m_lock;
      ct = b_we && b_addr == A_CTL && !m_lock;
      ex = 0; tr = 0;
      if (m_frozen) begin
        // nothing moves
      end else if (ld && m_en) begin
        m_cnt = b_wdata; ex = (b_wdata == 0);
      end else if (ct && b_wdata[0] && !m_en) begin
        m_cnt = m_load;
      end else if (m_en && !(m_stall && b_halt)) begin
        if (m_cnt == 0) begin ex = 1; m_cnt = m_load; end
        else m_cnt = m_cnt - 1;
      end
      if (ex && m_ris && m_rsten) begin tr = 1; m_cnt = 0; end
      if (ex) m_ris = 1;
      else if (b_we && b_addr == A_ICR && b_wdata[0]) m_ris = 0;
      if (tr) m_rst_left = 4;
      else if (m_rst_left > 0) m_rst_left--;
      if (tr) m_frozen = 1;
      if (ld) m_load = b_wdata;
      if (ct) begin m_en = m_en | b_wdata[0]; m_rsten = b_wdata[1]; m_itype = b_wdata[2]; end
      if (b_we && b_addr == A_TEST) m_stall = b_wdata[8];
      if (b_we && b_addr == A_LOCK) m_lock = (b_wdata != KEY);
    end
  end

  function automatic logic [31:0] mread(input logic [11:0] a, input logic r);
    logic [31:0] v;
    v = 0;
    if (r) begin
      case (a)
        A_LOAD: v = m_load;
        A_VAL:  v = m_cnt;
        A_CTL:  v = {29'd0, m_itype, m_rsten, m_en};
        A_RIS:  v = {31'd0, m_ris};
        A_MIS:  v = {31'd0, m_ris & m_en};
        A_TEST: v = {23'd0, m_stall, 8'd0};
        A_LOCK: v = {31'd0, m_lock};
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [11:0] a, input logic [31:0] d, input logic w, input logic r);
    @(negedge clk);
    b_addr = a; b_wdata = d; b_we = w; b_re = r;
    #1;
    chk("irq_o", {31'd0, irq_o}, {31'd0, m_ris & m_en & ~m_itype});   // R8
    chk("nmi_o", {31'd0, nmi_o}, {31'd0, m_ris & m_en & m_itype});    // R8
    chk("sysrst_o", {31'd0, sysrst_o}, {31'd0, m_rst_left != 0});     // R6
    chk("bus_rdata", b_rdata, mread(a, r));                           // R11
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(a, d, 1'b1, 1'b0); endtask
  task automatic rd(input logic [11:0] a); cyc(a, 32'd0, 1'b0, 1'b1); endtask
  task automatic watch(input int n); repeat (n) rd(A_VAL); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; b_addr = 0; b_wdata = 0; b_we = 0; b_re = 0; b_halt = 0;
    cur_req = "R1";
    repeat (3) cyc(A_LOAD, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    rd(A_LOAD); rd(A_VAL); rd(A_CTL); rd(A_RIS); rd(A_MIS); rd(A_TEST); rd(A_LOCK);
    cur_req = "R11";
    rd(A_BAD); rd(A_ICR); cyc(A_LOAD, 0, 0, 0);

    // lock semantics and gated writes
    cur_req = "R2";
    wr(A_LOCK, 32'h1); rd(A_LOCK);
    cur_req = "R3";
    wr(A_LOAD, 32'd5); wr(A_CTL, 32'h7); rd(A_LOAD); rd(A_CTL);
    wr(A_TEST, 32'h100); rd(A_TEST); wr(A_TEST, 32'h0);
    cur_req = "R2";
    wr(A_LOCK, KEY + 1); rd(A_LOCK);
    wr(A_LOCK, KEY); rd(A_LOCK);

    // enable, count, expire, clear
    cur_req = "R5";
    wr(A_LOAD, 32'd3); wr(A_CTL, 32'h1);
    watch(10);
    cur_req = "R9";
    rd(A_RIS); rd(A_MIS); wr(A_ICR, 32'h1); rd(A_RIS); rd(A_MIS);
    cur_req = "R4";
    wr(A_CTL, 32'h0); rd(A_CTL); watch(3);

    // debug stall
    cur_req = "R10";
    wr(A_TEST, 32'h100);
    b_halt = 1; watch(6); b_halt = 0; watch(2);
    wr(A_TEST, 32'h0); b_halt = 1; watch(6); b_halt = 0;

    // immediate load
    cur_req = "R7";
    wr(A_LOAD, 32'd20); watch(3);
    wr(A_ICR, 32'h1);
    wr(A_LOAD, 32'd0); rd(A_RIS);
    wr(A_ICR, 32'h1); rd(A_RIS);
    wr(A_LOAD, 32'd6); wr(A_ICR, 32'h1); watch(4);

    // non-maskable routing
    cur_req = "R8";
    wr(A_CTL, 32'h5); watch(10);
    wr(A_ICR, 32'h1); wr(A_CTL, 32'h1); watch(8);

    // clear colliding with expiry (zero load expires every cycle)
    cur_req = "R9";
    wr(A_LOAD, 32'd0);
    repeat (4) wr(A_ICR, 32'h1);
    rd(A_RIS);
    wr(A_LOAD, 32'd4); wr(A_ICR, 32'h1);

    // repeated expiry without escalation, then with it
    cur_req = "R6";
    watch(16);
    wr(A_ICR, 32'h1); wr(A_LOCK, KEY); wr(A_CTL, 32'h3);
    watch(20);
    wr(A_LOAD, 32'd9); watch(4); rd(A_RIS);

    // hardware reset clears everything again
    cur_req = "R1";
    @(negedge clk); rst_n = 0;
    cyc(A_LOAD, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    rd(A_CTL); rd(A_LOAD); rd(A_VAL); rd(A_RIS);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule